// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block maps a 14-bit virtual address onto a 16-bit physical address through a four-entry segment table held in flops. The upper two address bits pick a table entry and the lower twelve bits are an offset into that segment. Each entry carries a valid flag, a physical base, a length and three permission bits: execute, read and write. The physical result is the base plus the offset. Every access is checked against the selected entry. A missing segment, an offset past the segment end, or an access kind the entry does not permit produces a fault with a cause code instead of an address.

A request is captured on the clock edge where `req_valid` is high. The translation is computed combinationally from that captured request and the current table contents, so the result appears during the cycle after acceptance. A separate write port loads one table entry per cycle. The write takes effect only when the privilege flag accompanies it. Two entries may describe the same physical range with different permissions, for example a read-only view and a writable view of one region.

Top module: `seg_xlat_unit`

## Requirements
- R1: A request accepted on a rising edge (`req_valid` high) yields `rsp_valid` high for the following cycle only; with no request at that edge `rsp_valid` is low.
- R2: For an access without a fault, `rsp_paddr` equals the entry base plus the 12-bit offset, modulo 2^16.
- R3: When the selected entry's valid flag is clear, the response faults with cause 2'b01.
- R4: An offset greater than or equal to the entry length faults with cause 2'b10; a length of zero makes every offset fault.
- R5: Access kind encoding is 2'b00 fetch, 2'b01 load, 2'b10 store, 2'b11 reserved. Permission bit 0 allows fetch, bit 1 allows load and bit 2 allows store. A kind whose bit is clear, or the reserved kind, faults with cause 2'b11.
- R6: When several faults apply, the reported cause follows the priority invalid, then bounds, then permission.
- R7: `rsp_fault` is high exactly when a valid response has a nonzero cause. A faulted or idle response drives `rsp_paddr` to zero, and an idle response drives cause 2'b00.
- R8: A table write with `cfg_we` high and `cfg_priv` low leaves every entry unchanged.
- R9: After reset all entries are invalid and `rsp_valid` is low.
- R10: Entries are independent, so two entries with the same base and length but different permissions give different outcomes for the same access kind.
- R11: A privileged write at the same edge that accepts a request is visible to the response to that request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_vaddr | input | 14 | Virtual address: segment number [13:12], offset [11:0] |
| req_kind | input | 2 | Access kind (R5 encoding) |
| cfg_we | input | 1 | Table write strobe |
| cfg_priv | input | 1 | Privilege flag qualifying the write |
| cfg_idx | input | 2 | Entry to write |
| cfg_base | input | 16 | Physical base for the entry |
| cfg_len | input | 13 | Segment length in bytes, 0 to 4096 |
| cfg_perm | input | 3 | Permissions {write, read, execute} |
| cfg_valid | input | 1 | Valid flag for the entry |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 16 | Translated physical address, zero on fault |
| rsp_fault | output | 1 | Response carries a fault |
| rsp_cause | output | 2 | 00 none, 01 invalid, 10 bounds, 11 permission |

## Verification
Every translation result, fault flag and cause code is due in the cycle right after the edge that accepts the request. A table write is due at that same edge, so a request issued alongside a write already sees the new entry. The bench drives stimulus on the falling edge and compares all four outputs with its reference model on the next falling edge. This places each sample exactly one register stage after its cause. An ignored unprivileged write is shown by a later request to the same entry, whose response must still match the table as it was before.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'b00,
    ACC_LOAD  = 2'b01,
    ACC_STORE = 2'b10,
    ACC_RSVD  = 2'b11
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE    = 2'b00,
    CAUSE_INVALID = 2'b01,
    CAUSE_BOUNDS  = 2'b10,
    CAUSE_PERM    = 2'b11
  } fault_cause_e;

  localparam int PERM_BITS = 3;
  localparam int PERM_EXEC = 0;
  localparam int PERM_READ = 1;
  localparam int PERM_WRITE = 2;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int SEG_BITS = 2,
  parameter int PA_BITS  = 16,
  parameter int LEN_BITS = 13,
  localparam int NSEG    = 1 << SEG_BITS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic                              wr_priv,
  input  logic [SEG_BITS-1:0]               wr_idx,
  input  logic [PA_BITS-1:0]                wr_base,
  input  logic [LEN_BITS-1:0]               wr_len,
  input  logic [seg_xlat_pkg::PERM_BITS-1:0] wr_perm,
  input  logic                              wr_valid,
  output logic [PA_BITS-1:0]                ent_base  [NSEG],
  output logic [LEN_BITS-1:0]               ent_len   [NSEG],
  output logic [seg_xlat_pkg::PERM_BITS-1:0] ent_perm [NSEG],
  output logic                              ent_valid [NSEG]
);

  logic wr_ok;
  assign wr_ok = wr_en & wr_priv;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic                               ld;
    logic [PA_BITS-1:0]                 base_q, base_d;
    logic [LEN_BITS-1:0]                len_q, len_d;
    logic [seg_xlat_pkg::PERM_BITS-1:0] perm_q, perm_d;
    logic                               vld_q, vld_d;

    assign ld = wr_ok && (wr_idx == SEG_BITS'(g));

    always_comb begin
      base_d = base_q;
      len_d  = len_q;
      perm_d = perm_q;
      vld_d  = vld_q;
      if (ld) begin
        base_d = wr_base;
        len_d  = wr_len;
        perm_d = wr_perm;
        vld_d  = wr_valid;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q <= '0;
        len_q  <= '0;
        perm_q <= '0;
        vld_q  <= 1'b0;
      end else begin
        base_q <= base_d;
        len_q  <= len_d;
        perm_q <= perm_d;
        vld_q  <= vld_d;
      end
    end

    assign ent_base[g]  = base_q;
    assign ent_len[g]   = len_q;
    assign ent_perm[g]  = perm_q;
    assign ent_valid[g] = vld_q;
  end

endmodule

// File: rtl/seg_req_reg.sv
module seg_req_reg #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [SEG_BITS-1:0] in_seg,
  input  logic [OFF_BITS-1:0] in_off,
  input  logic [1:0]          in_kind,
  output logic                q_valid,
  output logic [SEG_BITS-1:0] q_seg,
  output logic [OFF_BITS-1:0] q_off,
  output logic [1:0]          q_kind
);

  logic                valid_d;
  logic [SEG_BITS-1:0] seg_d;
  logic [OFF_BITS-1:0] off_d;
  logic [1:0]          kind_d;

  always_comb begin
    valid_d = in_valid;
    seg_d   = q_seg;
    off_d   = q_off;
    kind_d  = q_kind;
    if (in_valid) begin
      seg_d  = in_seg;
      off_d  = in_off;
      kind_d = in_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_seg   <= '0;
      q_off   <= '0;
      q_kind  <= '0;
    end else begin
      q_valid <= valid_d;
      q_seg   <= seg_d;
      q_off   <= off_d;
      q_kind  <= kind_d;
    end
  end

endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  parameter int LEN_BITS = 13,
  localparam int NSEG    = 1 << SEG_BITS
) (
  input  logic                 req_v,
  input  logic [SEG_BITS-1:0]  req_seg,
  input  logic [OFF_BITS-1:0]  req_off,
  input  logic [1:0]           req_kind,
  input  logic [PA_BITS-1:0]   ent_base  [NSEG],
  input  logic [LEN_BITS-1:0]  ent_len   [NSEG],
  input  logic [PERM_BITS-1:0] ent_perm  [NSEG],
  input  logic                 ent_valid [NSEG],
  output logic [PA_BITS-1:0]   paddr,
  output fault_cause_e         cause
);

  logic [PA_BITS-1:0]   sel_base;
  logic [LEN_BITS-1:0]  sel_len;
  logic [PERM_BITS-1:0] sel_perm;
  logic                 sel_vld;
  logic                 in_range;
  logic                 perm_ok;

  always_comb begin
    sel_base = ent_base[req_seg];
    sel_len  = ent_len[req_seg];
    sel_perm = ent_perm[req_seg];
    sel_vld  = ent_valid[req_seg];
    in_range = LEN_BITS'(req_off) < sel_len;
    unique case (acc_kind_e'(req_kind))
      ACC_FETCH: perm_ok = sel_perm[PERM_EXEC];
      ACC_LOAD:  perm_ok = sel_perm[PERM_READ];
      ACC_STORE: perm_ok = sel_perm[PERM_WRITE];
      default:   perm_ok = 1'b0;
    endcase
  end

  always_comb begin
    cause = CAUSE_NONE;
    paddr = '0;
    if (req_v) begin
      if (!sel_vld)       cause = CAUSE_INVALID;
      else if (!in_range) cause = CAUSE_BOUNDS;
      else if (!perm_ok)  cause = CAUSE_PERM;
      if (cause == CAUSE_NONE) paddr = sel_base + PA_BITS'(req_off);
    end
  end

endmodule

// File: rtl/seg_xlat_unit.sv
module seg_xlat_unit
  import seg_xlat_pkg::*;
#(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 12,
  parameter int PA_BITS  = 16,
  localparam int VA_BITS  = SEG_BITS + OFF_BITS,
  localparam int LEN_BITS = OFF_BITS + 1,
  localparam int NSEG     = 1 << SEG_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [VA_BITS-1:0]   req_vaddr,
  input  logic [1:0]           req_kind,
  input  logic                 cfg_we,
  input  logic                 cfg_priv,
  input  logic [SEG_BITS-1:0]  cfg_idx,
  input  logic [PA_BITS-1:0]   cfg_base,
  input  logic [LEN_BITS-1:0]  cfg_len,
  input  logic [PERM_BITS-1:0] cfg_perm,
  input  logic                 cfg_valid,
  output logic                 rsp_valid,
  output logic [PA_BITS-1:0]   rsp_paddr,
  output logic                 rsp_fault,
  output logic [1:0]           rsp_cause
);

  logic [PA_BITS-1:0]   tbl_base  [NSEG];
  logic [LEN_BITS-1:0]  tbl_len   [NSEG];
  logic [PERM_BITS-1:0] tbl_perm  [NSEG];
  logic                 tbl_valid [NSEG];

  logic                 q_valid;
  logic [SEG_BITS-1:0]  q_seg;
  logic [OFF_BITS-1:0]  q_off;
  logic [1:0]           q_kind;
  fault_cause_e         cause;

  // Flattened table view for the bound checker
  logic [NSEG-1:0]           tbl_valid_vec;
  logic [NSEG*PA_BITS-1:0]   tbl_base_flat;
  logic [NSEG*LEN_BITS-1:0]  tbl_len_flat;
  logic [NSEG*PERM_BITS-1:0] tbl_perm_flat;

  for (genvar g = 0; g < NSEG; g++) begin : g_flat
    assign tbl_valid_vec[g]                          = tbl_valid[g];
    assign tbl_base_flat[g*PA_BITS +: PA_BITS]       = tbl_base[g];
    assign tbl_len_flat[g*LEN_BITS +: LEN_BITS]      = tbl_len[g];
    assign tbl_perm_flat[g*PERM_BITS +: PERM_BITS]   = tbl_perm[g];
  end

  seg_table #(.SEG_BITS(SEG_BITS), .PA_BITS(PA_BITS), .LEN_BITS(LEN_BITS)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_priv  (cfg_priv),
    .wr_idx   (cfg_idx),
    .wr_base  (cfg_base),
    .wr_len   (cfg_len),
    .wr_perm  (cfg_perm),
    .wr_valid (cfg_valid),
    .ent_base (tbl_base),
    .ent_len  (tbl_len),
    .ent_perm (tbl_perm),
    .ent_valid(tbl_valid)
  );

  seg_req_reg #(.SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS)) u_req (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(req_valid),
    .in_seg  (req_vaddr[VA_BITS-1:OFF_BITS]),
    .in_off  (req_vaddr[OFF_BITS-1:0]),
    .in_kind (req_kind),
    .q_valid (q_valid),
    .q_seg   (q_seg),
    .q_off   (q_off),
    .q_kind  (q_kind)
  );

  seg_check #(
    .SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS), .LEN_BITS(LEN_BITS)
  ) u_check (
    .req_v    (q_valid),
    .req_seg  (q_seg),
    .req_off  (q_off),
    .req_kind (q_kind),
    .ent_base (tbl_base),
    .ent_len  (tbl_len),
    .ent_perm (tbl_perm),
    .ent_valid(tbl_valid),
    .paddr    (rsp_paddr),
    .cause    (cause)
  );

  assign rsp_valid = q_valid;
  assign rsp_cause = cause;
  assign rsp_fault = q_valid && (cause != CAUSE_NONE);

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int SEG_BITS  = 2,
  parameter int OFF_BITS  = 12,
  parameter int PA_BITS   = 16,
  parameter int LEN_BITS  = 13,
  parameter int PERM_BITS = 3,
  localparam int NSEG     = 1 << SEG_BITS
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      req_valid,
  input logic                      cfg_we,
  input logic                      cfg_priv,
  input logic                      rsp_valid,
  input logic [PA_BITS-1:0]        rsp_paddr,
  input logic                      rsp_fault,
  input logic [1:0]                rsp_cause,
  input logic [SEG_BITS-1:0]       q_seg,
  input logic [OFF_BITS-1:0]       q_off,
  input logic [NSEG-1:0]           tbl_valid_vec,
  input logic [NSEG*PA_BITS-1:0]   tbl_base_flat,
  input logic [NSEG*LEN_BITS-1:0]  tbl_len_flat,
  input logic [NSEG*PERM_BITS-1:0] tbl_perm_flat
);

  logic [LEN_BITS-1:0] sel_len;
  assign sel_len = tbl_len_flat[int'(q_seg)*LEN_BITS +: LEN_BITS];

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  assert_no_rsp_without_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_paddr == '0 && !rsp_fault && rsp_cause == 2'b00));

  assert_fault_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0);

  assert_unpriv_write_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_priv) |=> ($stable(tbl_valid_vec) && $stable(tbl_base_flat)
                               && $stable(tbl_len_flat) && $stable(tbl_perm_flat)));

  assert_ok_only_on_valid_seg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> tbl_valid_vec[q_seg]);

  assert_ok_only_in_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> (LEN_BITS'(q_off) < sel_len));

endmodule

bind seg_xlat_unit seg_xlat_chk #(
  .SEG_BITS(SEG_BITS), .OFF_BITS(OFF_BITS), .PA_BITS(PA_BITS),
  .LEN_BITS(LEN_BITS), .PERM_BITS(seg_xlat_pkg::PERM_BITS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .cfg_we       (cfg_we),
  .cfg_priv     (cfg_priv),
  .rsp_valid    (rsp_valid),
  .rsp_paddr    (rsp_paddr),
  .rsp_fault    (rsp_fault),
  .rsp_cause    (rsp_cause),
  .q_seg        (q_seg),
  .q_off        (q_off),
  .tbl_valid_vec(tbl_valid_vec),
  .tbl_base_flat(tbl_base_flat),
  .tbl_len_flat (tbl_len_flat),
  .tbl_perm_flat(tbl_perm_flat)
);

// File: tb/tb_seg_xlat_unit.sv
module tb_seg_xlat_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_vaddr = '0;
  logic [1:0]  req_kind = '0;
  logic        cfg_we = 1'b0;
  logic        cfg_priv = 1'b0;
  logic [1:0]  cfg_idx = '0;
  logic [15:0] cfg_base = '0;
  logic [12:0] cfg_len = '0;
  logic [2:0]  cfg_perm = '0;
  logic        cfg_valid = 1'b0;
  logic        rsp_valid;
  logic [15:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  int checks = 0;
  int errors = 0;

  // Reference model of the table
  int m_base [4];
  int m_len  [4];
  int m_perm [4];
  bit m_vld  [4];
  logic [19:0] expected;

  always #2.5 clk = ~clk;

  seg_xlat_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_idx(cfg_idx),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_perm(cfg_perm), .cfg_valid(cfg_valid),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .rsp_cause(rsp_cause)
  );

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1: actual=hung expected=done");
    finish_run();
  end

  task automatic check(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual v=%0b pa=%h f=%0b c=%0d expected v=%0b pa=%h f=%0b c=%0d",
               tag, act[19], act[18:3], act[2], act[1:0], exp[19], exp[18:3], exp[2], exp[1:0]);
    end
  endtask

  function automatic logic [19:0] model(input logic rv, input logic [13:0] va, input logic [1:0] k);
    int s, o, c, pa;
    bit ok;
    if (!rv) return '0;
    s = int'(va[13:12]);
    o = int'(va[11:0]);
    case (k)
      2'b00: ok = m_perm[s][0];
      2'b01: ok = m_perm[s][1];
      2'b10: ok = m_perm[s][2];
      default: ok = 1'b0;
    endcase
    if (!m_vld[s]) c = 1;
    else if (o >= m_len[s]) c = 2;
    else if (!ok) c = 3;
    else c = 0;
    pa = (c == 0) ? ((m_base[s] + o) % 65536) : 0;
    return {1'b1, 16'(pa), (c != 0), 2'(c)};
  endfunction

  // One cycle: drive at falling edge, compare at the next falling edge
  task automatic cyc(input logic rv, input logic [13:0] va, input logic [1:0] k,
                     input logic we, input logic pv, input logic [1:0] idx,
                     input logic [15:0] b, input logic [12:0] l, input logic [2:0] p,
                     input logic vl, input string tag);
    req_valid = rv; req_vaddr = va; req_kind = k;
    cfg_we = we; cfg_priv = pv; cfg_idx = idx; cfg_base = b;
    cfg_len = l; cfg_perm = p; cfg_valid = vl;
    if (we && pv) begin
      m_base[idx] = int'(b); m_len[idx] = int'(l);
      m_perm[idx] = int'(p); m_vld[idx] = vl;
    end
    expected = model(rv, va, k);
    @(negedge clk);
    check(tag, {rsp_valid, rsp_paddr, rsp_fault, rsp_cause}, expected);
  endtask

  task automatic req(input logic [13:0] va, input logic [1:0] k, input string tag);
    cyc(1'b1, va, k, 1'b0, 1'b0, 2'd0, 16'd0, 13'd0, 3'd0, 1'b0, tag);
  endtask

  task automatic wr(input logic pv, input logic [1:0] idx, input logic [15:0] b,
                    input logic [12:0] l, input logic [2:0] p, input logic vl, input string tag);
    cyc(1'b0, 14'd0, 2'd0, 1'b1, pv, idx, b, l, p, vl, tag);
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 14'd0, 2'd0, 1'b0, 1'b0, 2'd0, 16'd0, 13'd0, 3'd0, 1'b0, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_base[i] = 0; m_len[i] = 0; m_perm[i] = 0; m_vld[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: reset state
    check("R9 reset idle", {rsp_valid, rsp_paddr, rsp_fault, rsp_cause}, 20'd0);
    req(14'h0240, 2'b00, "R9 entries invalid after reset");
    req(14'h3001, 2'b01, "R3 invalid segment");
    // Program table: code, data, stack; segment 2 left unused
    wr(1'b1, 2'd0, 16'h4000, 13'h0700, 3'b011, 1'b1, "R1 idle during write");
    wr(1'b1, 2'd1, 16'h0500, 13'h0500, 3'b110, 1'b1, "R1 idle during write");
    wr(1'b1, 2'd3, 16'h2000, 13'h1000, 3'b110, 1'b1, "R1 idle during write");
    req(14'h0240, 2'b00, "R2 fetch 0x240 to 0x4240");
    req(14'h06FF, 2'b01, "R2 last byte of code");
    req(14'h0700, 2'b01, "R4 offset equals length");
    req(14'h0240, 2'b10, "R5 store to read-only");
    req(14'h1100, 2'b00, "R5 fetch without execute");
    req(14'h1100, 2'b10, "R2 store to data");
    req(14'h2010, 2'b01, "R3 unused segment");
    req(14'h3FFF, 2'b10, "R2 top of stack");
    req(14'h0010, 2'b11, "R5 reserved kind");
    idle("R7 idle response");
    // R8: unprivileged write must not take effect
    wr(1'b0, 2'd2, 16'h1000, 13'h1000, 3'b111, 1'b1, "R8 unpriv write");
    req(14'h2010, 2'b01, "R8 entry unchanged");
    wr(1'b0, 2'd0, 16'h7000, 13'h0000, 3'b000, 1'b0, "R8 unpriv write");
    req(14'h0240, 2'b00, "R8 code entry unchanged");
    // R6: priority
    req(14'h2FFF, 2'b11, "R6 invalid wins");
    req(14'h0800, 2'b10, "R6 bounds beats permission");
    // R10: alias with different permissions
    wr(1'b1, 2'd2, 16'h4000, 13'h0700, 3'b110, 1'b1, "R10 alias write");
    req(14'h2240, 2'b10, "R10 writable alias");
    req(14'h0240, 2'b10, "R10 read-only original");
    // R2 wraparound, R4 zero length
    wr(1'b1, 2'd1, 16'hFF00, 13'h1000, 3'b111, 1'b1, "R1 idle during write");
    req(14'h1200, 2'b01, "R2 address wraps");
    wr(1'b1, 2'd1, 16'h0100, 13'h0000, 3'b111, 1'b1, "R1 idle during write");
    req(14'h1000, 2'b01, "R4 zero length");
    // R11: write and request on the same edge
    cyc(1'b1, 14'h1020, 2'b01, 1'b1, 1'b1, 2'd1, 16'h0800, 13'h0100, 3'b010, 1'b1,
        "R11 same-edge write visible");
    // Random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[0], 14'($urandom), r[2:1], r[3] & r[4], r[5], r[7:6], 16'($urandom),
          13'($urandom % 4097), r[10:8], r[11], "R1 random mix");
    end
    idle("R1 final idle");
    finish_run();
  end

endmodule